// File: doc/BRIEF.md
# Almost-Flag Offset Programmer

This block configures and holds the two thresholds used by the partial-fill flags of a 4096-word FIFO: an almost-empty offset (X) and an almost-full offset (Y). It also turns the fill and free word counts, supplied by the FIFO's pointer logic, into the two active-low almost flags. The memory array and pointers live elsewhere. This block only owns the thresholds and the comparisons.

The loading method is picked once, from three select pins, while the master reset is low. The value on the last clock edge of the reset is the one kept. There are three methods:
- **Preset:** both offsets take one of five fixed values as the reset ends.
- **Parallel:** two words are taken from a 36-bit configuration port with a valid/ready handshake.
- **Serial:** one bit is shifted in per clock from the select pins, which are reused as a serial data pin and an active-low serial enable.

A partial reset never touches the configuration. While it is held low it only pauses loading.

The configuration port obeys a simple back-pressure rule. A word is taken on a clock edge only when `cfg_valid` and `cfg_ready` are both high. `cfg_ready` is high only in parallel mode, outside both resets, and before loading has completed. A word offered while ready is low is dropped, and the source must hold it until ready is seen.

Top module: `ofs_cfg_loader`

## Requirements
- R1: The select code sampled at master reset maps to presets as follows: 000→8, 001→16, 010→64, 011→256, 100→1024, and 111 (reserved)→8. In preset mode, X and Y both equal the preset and `prog_done` is 1 on the first clock after the reset ends.
- R2: Codes 101 (parallel) and 110 (serial) select the other methods. After the master reset ends, changes on `sel` or strobes on the configuration port do not change the chosen method, and in preset mode they do not change X or Y.
- R3: In serial mode, each rising edge with `sel[1]` low shifts `sel[0]` into the 24-bit register Y:X. The first bit taken ends in Y bit 11 and the last bit taken ends in X bit 0. Edges with `sel[1]` high shift nothing.
- R4: `prog_done` rises on the edge that takes the 24th serial bit and not before. Once it is set, X, Y and `prog_done` hold until the next master reset, whatever the inputs do.
- R5: In parallel mode, the first accepted word loads X, and the second loads Y and sets `prog_done`. `cfg_ready` = master reset released AND partial reset released AND parallel mode AND not done. Words offered while `cfg_ready` is low are ignored.
- R6: The parallel offset field depends on the parity choice sampled with the method on `parity_sel`. With `parity_sel`=0 the field is `cfg_data[11:0]`. With `parity_sel`=1 data bit 8 is skipped and the field is {`cfg_data[12:9]`, `cfg_data[7:0]`}.
- R7: `ae_n` is 0 exactly when `fill_cnt` ≤ X.
- R8: `af_n` is 0 exactly when `free_cnt` ≤ Y.
- R9: While `prst_n` is low, X, Y, `prog_done` and the method are unchanged and no serial bit or parallel word is taken. Loading resumes where it stopped once `prst_n` returns high.
- R10: In parallel or serial mode, X and Y read 0 and `prog_done` reads 0 just after the master reset, until loading completes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Write-side clock |
| mrst_n | input | 1 | Master reset, active low, synchronous; method captured while low |
| prst_n | input | 1 | Partial reset, active low; pauses loading, keeps configuration |
| sel | input | 3 | Method select at reset; afterwards bit 0 is serial data and bit 1 is serial enable (active low) |
| parity_sel | input | 1 | Parity choice sampled during master reset; 1 skips data bit 8 in parallel loads |
| cfg_data | input | 36 | Parallel offset word |
| cfg_valid | input | 1 | Parallel word offered |
| cfg_ready | output | 1 | Parallel word accepted this edge if valid |
| fill_cnt | input | 13 | Words stored in the FIFO |
| free_cnt | input | 13 | Free locations in the FIFO |
| ofs_x | output | 12 | Almost-empty offset |
| ofs_y | output | 12 | Almost-full offset |
| ae_n | output | 1 | Almost-empty flag, active low |
| af_n | output | 1 | Almost-full flag, active low |
| prog_done | output | 1 | Offsets loaded |

## Verification
Every select code, including the reserved one, is applied through a reset, and the select and configuration inputs are then toggled to show that the preset stays fixed. A 24-bit serial pattern with uneven halves is shifted in with idle gaps and a partial-reset pause part way through. This pattern tells a correct bit order and count from a reversed, shifted or early-stopping register, and the done flag is checked after bit 23 and after bit 24. Parallel loads use one pair of words under both parity choices, so that dropping or keeping data bit 8 gives different offsets, and a third word shows that loading stops after the second. Fill and free counts are swept at, one below and one above each offset, and at the extremes, to pin down the inclusive comparisons.

// File: rtl/ofs_cfg_pkg.sv
package ofs_cfg_pkg;
  typedef enum logic [1:0] {
    LM_PRESET   = 2'd0,
    LM_PARALLEL = 2'd1,
    LM_SERIAL   = 2'd2
  } load_mode_e;

  // 101 -> parallel, 110 -> serial, all else preset (111 reserved -> preset 8)
  function automatic load_mode_e decode_mode(input logic [2:0] code);
    case (code)
      3'b101:  decode_mode = LM_PARALLEL;
      3'b110:  decode_mode = LM_SERIAL;
      default: decode_mode = LM_PRESET;
    endcase
  endfunction

  // Preset offsets are powers of two; return the exponent
  function automatic int unsigned preset_exp(input logic [2:0] code);
    case (code)
      3'b000:  preset_exp = 3;
      3'b001:  preset_exp = 4;
      3'b010:  preset_exp = 6;
      3'b011:  preset_exp = 8;
      3'b100:  preset_exp = 10;
      default: preset_exp = 3;
    endcase
  endfunction
endpackage

// File: rtl/ofs_mode_latch.sv
module ofs_mode_latch
  import ofs_cfg_pkg::*;
(
  input  logic       clk,
  input  logic       mrst_n,
  input  load_mode_e mode_d,
  input  logic       parity_d,
  output load_mode_e mode_q,
  output logic       parity_q
);
  // Track the pins every cycle of master reset; the last one sticks
  always_ff @(posedge clk) begin
    if (!mrst_n) begin
      mode_q   <= mode_d;
      parity_q <= parity_d;
    end
  end

  // R2: method is frozen outside master reset
  p_mode_frozen_r2: assert property (@(posedge clk) disable iff (!mrst_n)
    mrst_n |=> ($stable(mode_q) && $stable(parity_q)));
endmodule

// File: rtl/ofs_loader.sv
module ofs_loader
  import ofs_cfg_pkg::*;
#(
  parameter int OFS_W  = 12,
  parameter int DATA_W = 36
) (
  input  logic              clk,
  input  logic              mrst_n,
  input  logic              prst_n,
  input  load_mode_e        mode_d,
  input  logic [OFS_W-1:0]  preset_d,
  input  load_mode_e        mode_q,
  input  logic              parity_q,
  input  logic              ser_data,
  input  logic              ser_en_n,
  input  logic [DATA_W-1:0] cfg_data,
  input  logic              cfg_valid,
  output logic              cfg_ready,
  output logic [OFS_W-1:0]  ofs_x,
  output logic [OFS_W-1:0]  ofs_y,
  output logic              done
);
  localparam int SER_BITS = 2 * OFS_W;
  localparam int BC_W     = $clog2(SER_BITS + 1);

  logic [SER_BITS-1:0] yx;
  logic [BC_W-1:0]     bit_cnt;
  logic                second_word;
  logic [OFS_W-1:0]    plain_val;
  logic [OFS_W-1:0]    par_val;
  logic [OFS_W-1:0]    field_val;
  logic                unused_hi;

  assign plain_val = cfg_data[OFS_W-1:0];

  generate
    if (OFS_W > 8) begin : g_skip_b8
      assign par_val   = {cfg_data[OFS_W:9], cfg_data[7:0]};
      assign unused_hi = ^{cfg_data[DATA_W-1:OFS_W+1]};
    end else begin : g_no_skip
      assign par_val   = cfg_data[OFS_W-1:0];
      assign unused_hi = ^{cfg_data[DATA_W-1:OFS_W]};
    end
  endgenerate

  assign field_val = parity_q ? par_val : plain_val;
  assign cfg_ready = mrst_n && prst_n && (mode_q == LM_PARALLEL) && !done;
  assign ofs_x     = yx[OFS_W-1:0];
  assign ofs_y     = yx[SER_BITS-1:OFS_W];

  always_ff @(posedge clk) begin
    if (!mrst_n) begin
      yx          <= (mode_d == LM_PRESET) ? {preset_d, preset_d} : '0;
      done        <= (mode_d == LM_PRESET);
      bit_cnt     <= '0;
      second_word <= 1'b0;
    end else if (prst_n && !done) begin
      if (mode_q == LM_SERIAL && !ser_en_n) begin
        yx      <= {yx[SER_BITS-2:0], ser_data};
        bit_cnt <= bit_cnt + 1'b1;
        if (bit_cnt == BC_W'(SER_BITS - 1)) done <= 1'b1;
      end else if (cfg_valid && cfg_ready) begin
        if (!second_word) begin
          yx[OFS_W-1:0] <= field_val;
        end else begin
          yx[SER_BITS-1:OFS_W] <= field_val;
          done                 <= 1'b1;
        end
        second_word <= ~second_word;
      end
    end
  end

  // R4: done is sticky and freezes the offsets
  p_done_sticky_r4: assert property (@(posedge clk) disable iff (!mrst_n)
    done |=> done);
  p_frozen_after_done_r4: assert property (@(posedge clk) disable iff (!mrst_n)
    done |=> ($stable(ofs_x) && $stable(ofs_y)));
  // R3: the serial count never passes the register length
  p_bitcnt_limit_r3: assert property (@(posedge clk) disable iff (!mrst_n)
    bit_cnt <= BC_W'(SER_BITS));
  // R5: no acceptance once complete
  p_ready_not_done_r5: assert property (@(posedge clk) disable iff (!mrst_n)
    cfg_ready |-> !done);
  // R9: partial reset pauses all loading
  p_prst_hold_r9: assert property (@(posedge clk) disable iff (!mrst_n)
    !prst_n |=> ($stable(ofs_x) && $stable(ofs_y) && $stable(done)));
endmodule

// File: rtl/ofs_flag_cmp.sv
module ofs_flag_cmp #(
  parameter int CNT_W = 13,
  parameter int OFS_W = 12
) (
  input  logic             clk,
  input  logic             mrst_n,
  input  logic [CNT_W-1:0] count,
  input  logic [OFS_W-1:0] ofs,
  output logic             flag_n
);
  assign flag_n = !(count <= CNT_W'(ofs));

  // R7 (almost-empty instance) and R8 (almost-full instance): zero count always flags
  p_zero_count_flags_r7: assert property (@(posedge clk) disable iff (!mrst_n)
    (count == '0) |-> !flag_n);
endmodule

// File: rtl/ofs_cfg_loader.sv
module ofs_cfg_loader
  import ofs_cfg_pkg::*;
#(
  parameter int DEPTH  = 4096,
  parameter int DATA_W = 36,
  localparam int OFS_W = $clog2(DEPTH),
  localparam int CNT_W = OFS_W + 1
) (
  input  logic              clk,
  input  logic              mrst_n,
  input  logic              prst_n,
  input  logic [2:0]        sel,
  input  logic              parity_sel,
  input  logic [DATA_W-1:0] cfg_data,
  input  logic              cfg_valid,
  output logic              cfg_ready,
  input  logic [CNT_W-1:0]  fill_cnt,
  input  logic [CNT_W-1:0]  free_cnt,
  output logic [OFS_W-1:0]  ofs_x,
  output logic [OFS_W-1:0]  ofs_y,
  output logic              ae_n,
  output logic              af_n,
  output logic              prog_done
);
  load_mode_e       mode_d;
  load_mode_e       mode_q;
  logic             parity_q;
  logic [OFS_W-1:0] preset_d;

  assign mode_d   = decode_mode(sel);
  assign preset_d = OFS_W'(1) << preset_exp(sel);

  ofs_mode_latch u_mode (
    .clk      (clk),
    .mrst_n   (mrst_n),
    .mode_d   (mode_d),
    .parity_d (parity_sel),
    .mode_q   (mode_q),
    .parity_q (parity_q)
  );

  ofs_loader #(.OFS_W(OFS_W), .DATA_W(DATA_W)) u_load (
    .clk       (clk),
    .mrst_n    (mrst_n),
    .prst_n    (prst_n),
    .mode_d    (mode_d),
    .preset_d  (preset_d),
    .mode_q    (mode_q),
    .parity_q  (parity_q),
    .ser_data  (sel[0]),
    .ser_en_n  (sel[1]),
    .cfg_data  (cfg_data),
    .cfg_valid (cfg_valid),
    .cfg_ready (cfg_ready),
    .ofs_x     (ofs_x),
    .ofs_y     (ofs_y),
    .done      (prog_done)
  );

  ofs_flag_cmp #(.CNT_W(CNT_W), .OFS_W(OFS_W)) u_ae (
    .clk    (clk),
    .mrst_n (mrst_n),
    .count  (fill_cnt),
    .ofs    (ofs_x),
    .flag_n (ae_n)
  );

  ofs_flag_cmp #(.CNT_W(CNT_W), .OFS_W(OFS_W)) u_af (
    .clk    (clk),
    .mrst_n (mrst_n),
    .count  (free_cnt),
    .ofs    (ofs_y),
    .flag_n (af_n)
  );

  // R1: preset mode is complete right after reset
  p_preset_done_r1: assert property (@(posedge clk) disable iff (!mrst_n)
    ($rose(mrst_n) && mode_q == LM_PRESET) |-> prog_done);
endmodule

// File: tb/ofs_cfg_loader_test.sv
`timescale 1ns/1ps
module ofs_cfg_loader_test;
  logic        clk = 1'b0;
  logic        mrst_n = 1'b0;
  logic        prst_n = 1'b1;
  logic [2:0]  sel = 3'b000;
  logic        parity_sel = 1'b0;
  logic [35:0] cfg_data = '0;
  logic        cfg_valid = 1'b0;
  logic        cfg_ready;
  logic [12:0] fill_cnt = '0;
  logic [12:0] free_cnt = 13'd4096;
  logic [11:0] ofs_x, ofs_y;
  logic        ae_n, af_n, prog_done;

  int n_tests = 0;
  int n_fail  = 0;
  bit finished = 0;
  string tag = "R1";

  // behavioural reference state
  int m_mode = 0;  // 0 preset, 1 parallel, 2 serial
  int m_par = 0, m_x = 0, m_y = 0, m_done = 0, m_bits = 0, m_step = 0;

  always #2.5 clk = ~clk;

  ofs_cfg_loader uut (
    .clk(clk), .mrst_n(mrst_n), .prst_n(prst_n), .sel(sel),
    .parity_sel(parity_sel), .cfg_data(cfg_data), .cfg_valid(cfg_valid),
    .cfg_ready(cfg_ready), .fill_cnt(fill_cnt), .free_cnt(free_cnt),
    .ofs_x(ofs_x), .ofs_y(ofs_y), .ae_n(ae_n), .af_n(af_n),
    .prog_done(prog_done)
  );

  function automatic int preset_of(input logic [2:0] s);
    case (s)
      3'd0: return 8;
      3'd1: return 16;
      3'd2: return 64;
      3'd3: return 256;
      3'd4: return 1024;
      default: return 8;
    endcase
  endfunction

  function automatic int field_of(input logic [35:0] w, input int p);
    if (p != 0) return int'(((w >> 1) & 36'hF00) | (w & 36'hFF));
    return int'(w & 36'hFFF);
  endfunction

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%0d expected=%0d at %0t", req, what, act, exp, $time);
    end
  endtask

  // reference model, advanced on every rising edge
  always @(posedge clk) begin
    if (!mrst_n) begin
      m_par  = int'(parity_sel);
      m_mode = (sel == 3'b101) ? 1 : (sel == 3'b110) ? 2 : 0;
      if (m_mode == 0) begin
        m_x = preset_of(sel); m_y = m_x; m_done = 1;
      end else begin
        m_x = 0; m_y = 0; m_done = 0;
      end
      m_bits = 0; m_step = 0;
    end else if (prst_n && m_done == 0) begin
      if (m_mode == 2 && !sel[1]) begin
        m_y = ((m_y << 1) | (m_x >> 11)) & 'hFFF;
        m_x = ((m_x << 1) | int'(sel[0])) & 'hFFF;
        m_bits++;
        if (m_bits == 24) m_done = 1;
      end else if (m_mode == 1 && cfg_valid) begin
        if (m_step == 0) m_x = field_of(cfg_data, m_par);
        else begin m_y = field_of(cfg_data, m_par); m_done = 1; end
        m_step = 1 - m_step;
      end
    end
  end

  // compare against the model on every falling edge
  always @(negedge clk) begin
    if (!finished && $time > 3) begin
      chk(tag, "ofs_x", int'(ofs_x), m_x);
      chk(tag, "ofs_y", int'(ofs_y), m_y);
      chk(tag, "prog_done", int'(prog_done), m_done);
      chk("R5", "cfg_ready", int'(cfg_ready),
          int'(mrst_n && prst_n && m_mode == 1 && m_done == 0));
      chk("R7", "ae_n", int'(ae_n), int'(!(int'(fill_cnt) <= m_x)));
      chk("R8", "af_n", int'(af_n), int'(!(int'(free_cnt) <= m_y)));
    end
  end

  task automatic step(input int n = 1);
    repeat (n) begin @(negedge clk); #1; end
  endtask

  task automatic do_reset(input logic [2:0] s, input logic p);
    step();
    mrst_n = 1'b0; sel = s; parity_sel = p; cfg_valid = 1'b0;
    step(3);
    mrst_n = 1'b1;
    step();
  endtask

  task automatic ser_bit(input logic b);
    sel = {1'b0, 1'b0, b};
    step();
    sel = 3'b010;
  endtask

  initial begin
    #1ms;
    if (!finished) begin
      n_fail++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      finished = 1;
      $finish;
    end
  end

  initial begin
    logic [23:0] pat;
    logic [35:0] w1, w2;
    pat = 24'hB2D6E1;
    w1  = 36'h5A5A51D3C;
    w2  = 36'h00000FF01;

    // R1 / R2: every select code, then disturbance after reset
    for (int c = 0; c < 8; c++) begin
      if (c == 5 || c == 6) continue;
      tag = "R1";
      do_reset(3'(c), 1'b0);
      chk("R1", "preset x", int'(ofs_x), preset_of(3'(c)));
      chk("R1", "preset y", int'(ofs_y), preset_of(3'(c)));
      chk("R1", "preset done", int'(prog_done), 1);
      tag = "R2";
      sel = 3'b101; cfg_data = w1; cfg_valid = 1'b1; step();
      sel = 3'b100; step();
      sel = 3'b110; step();
      cfg_valid = 1'b0; sel = 3'b000; step();
      chk("R2", "x after sel change", int'(ofs_x), preset_of(3'(c)));
      chk("R2", "ready in preset", int'(cfg_ready), 0);
    end

    // R7 / R8: sweep around the offsets (preset 64)
    tag = "R7";
    do_reset(3'b010, 1'b0);
    foreach (fill_cnt[i]) ;
    for (int v = 62; v <= 66; v++) begin
      fill_cnt = 13'(v); free_cnt = 13'(128 - v); step();
      chk("R7", "ae_n sweep", int'(ae_n), int'(v > 64));
      chk("R8", "af_n sweep", int'(af_n), int'((128 - v) > 64));
    end
    fill_cnt = 13'd0; free_cnt = 13'd4096; step();
    chk("R7", "ae_n at zero", int'(ae_n), 0);
    chk("R8", "af_n at full free", int'(af_n), 1);
    fill_cnt = 13'd4096; free_cnt = 13'd0; step();
    chk("R7", "ae_n at full", int'(ae_n), 1);
    chk("R8", "af_n at zero", int'(af_n), 0);

    // R3 / R4 / R9 / R10: serial load with gaps and a partial-reset pause
    tag = "R3";
    do_reset(3'b110, 1'b0);
    sel = 3'b010;
    chk("R10", "serial x at start", int'(ofs_x), 0);
    chk("R10", "serial done at start", int'(prog_done), 0);
    for (int i = 23; i >= 0; i--) begin
      if (i == 13) begin
        tag = "R9";
        prst_n = 1'b0;
        for (int k = 0; k < 3; k++) begin sel = {2'b00, 1'(k)}; step(); end
        chk("R9", "x held in prst", int'(ofs_x), int'(pat[23:14]) & 'hFFF);
        prst_n = 1'b1; sel = 3'b010; tag = "R3";
      end
      ser_bit(pat[i]);
      if (i % 5 == 0) step();
      if (i == 1) chk("R4", "done before bit 24", int'(prog_done), 0);
    end
    step();
    chk("R3", "serial x", int'(ofs_x), 'h6E1);
    chk("R3", "serial y", int'(ofs_y), 'hB2D);
    chk("R4", "serial done", int'(prog_done), 1);
    tag = "R4";
    for (int i = 0; i < 5; i++) ser_bit(1'b1);
    chk("R4", "x after extra bits", int'(ofs_x), 'h6E1);

    // R5 / R6: parallel, both parity choices
    for (int p = 0; p < 2; p++) begin
      tag = "R5";
      do_reset(3'b101, 1'(p));
      chk("R10", "parallel y at start", int'(ofs_y), 0);
      chk("R5", "ready after reset", int'(cfg_ready), 1);
      step(2);
      cfg_data = w1; cfg_valid = 1'b1; step(); cfg_valid = 1'b0;
      chk("R6", "x field", int'(ofs_x), field_of(w1, p));
      tag = "R9";
      prst_n = 1'b0; cfg_data = w2; cfg_valid = 1'b1; step(2);
      chk("R9", "y held in prst", int'(ofs_y), 0);
      prst_n = 1'b1; step(); cfg_valid = 1'b0; tag = "R5";
      chk("R6", "y field", int'(ofs_y), field_of(w2, p));
      chk("R5", "done after two", int'(prog_done), 1);
      cfg_data = 36'hFFFFFFFFF; cfg_valid = 1'b1; step(); cfg_valid = 1'b0;
      chk("R5", "third word ignored", int'(ofs_x), field_of(w1, p));
    end
    chk("R6", "parity skip differs", int'(field_of(w1, 0) != field_of(w1, 1)), 1);

    step(2);
    finished = 1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule